// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Matcher

This block computes, once per cell time, a conflict-free pairing of inputs to outputs for an N-port input-queued switch. Each input keeps one queue per output, so the block receives an N-by-N occupancy matrix and may see one input asking for several outputs in the same cell time. A start strobe captures the matrix. The block then runs a fixed number of matching rounds, one per clock. Each round has three steps. First, every still-free input asks for every still-free output it holds cells for. Next, every free output grants one of those requests. Last, every input that was granted accepts one of its grants.

Every output has a round-robin grant pointer and every input has a round-robin accept pointer. A grant pointer moves only when its grant is accepted. Pointers are changed only by pairings made in the first round. This keeps the output arbiters from falling into step with each other, and it ensures that a waiting request keeps its priority until it is served. Later rounds only fill in pairings between inputs and outputs that are still free.

Once the last round is done, a one-cycle done pulse marks the registered result. For each input the result is a valid bit and the output it was paired with. The result holds until the next accepted start.

Top module: `xbar_matcher`

## Requirements
- R1: After reset, done is low, every match valid bit is 0, every match port field is 0, and all grant and accept pointers are 0.
- R2: A start seen while idle captures req_mat, where bit i*N_PORTS+j set means input i has cells for output j. Done goes high for exactly one cycle, N_ITERS clock edges after the edge that sampled start. A start that arrives while rounds are still running is ignored.
- R3: At done, each input is paired with at most one output. Each output is paired with at most one input. Every pairing corresponds to a set bit of the captured matrix.
- R4: In each round, a free output grants the requesting free input that comes first in circular order, starting at that output's grant pointer.
- R5: An output's grant pointer moves to one past the granted input only if that grant is accepted in the first round of a cell time.
- R6: An input that holds grants accepts the first one in circular order from its accept pointer. In the first round, that pointer then moves to one past the accepted output.
- R7: Rounds after the first pair up only inputs and outputs that are still free, and they leave every pointer unchanged.
- R8: A start clears the earlier result. The result from the last round stays unchanged on the outputs until the next accepted start.
- R9: Input i's result sits at match_vld[i] and match_out[i*PW +: PW], with PW = clog2(N_PORTS). An input left unpaired shows valid 0 and port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a cell time; sampled only while idle |
| req_mat | input | N_PORTS*N_PORTS | Occupancy matrix, bit i*N_PORTS+j is input i to output j |
| done | output | 1 | One-cycle pulse: result is final |
| match_vld | output | N_PORTS | Per input: a pairing was found |
| match_out | output | N_PORTS*PW | Per input: index of the paired output |

## Verification
Done is due N_ITERS edges after the edge that samples start. The match fields change at every round edge and then stay fixed. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the start edge to done and compares that count with N_ITERS. A behavioural model steps once on each rising edge and keeps its own pointers, so every sample is compared against the value due in that same cycle. Hand-worked results for two back-to-back full-load cell times pin down the pointer motion. The check after done confirms that the result holds.

// File: rtl/xbar_match_pkg.sv
package xbar_match_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/xbar_rr_pick.sv
module xbar_rr_pick #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic [N-1:0]  pick
);
    always_comb begin
        logic found;
        int   idx;
        pick  = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr) + k) % N;
            if (!found && req[idx]) begin
                pick[idx] = 1'b1;
                found     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xbar_iter_stage.sv
module xbar_iter_stage #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0][N-1:0]  req,
    input  logic [N-1:0]         in_free,
    input  logic [N-1:0]         out_free,
    input  logic [N-1:0][PW-1:0] gptr,
    input  logic [N-1:0][PW-1:0] aptr,
    output logic [N-1:0][N-1:0]  acc
);
    logic [N-1:0][N-1:0] col_req;
    logic [N-1:0][N-1:0] gnt;
    logic [N-1:0][N-1:0] gin;

    always_comb begin
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                col_req[j][i] = req[i][j] & in_free[i] & out_free[j];
                gin[i][j]     = gnt[j][i];
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_port
        xbar_rr_pick #(.N(N), .PW(PW)) u_grant (
            .req  (col_req[g]),
            .ptr  (gptr[g]),
            .pick (gnt[g])
        );
        xbar_rr_pick #(.N(N), .PW(PW)) u_accept (
            .req  (gin[g]),
            .ptr  (aptr[g]),
            .pick (acc[g])
        );
    end
endmodule

// File: rtl/xbar_matcher.sv
module xbar_matcher
    import xbar_match_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int N_ITERS = (N_PORTS > 2) ? $clog2(N_PORTS) : 1,
    localparam int PW     = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [N_PORTS*N_PORTS-1:0] req_mat,
    output logic                       done,
    output logic [N_PORTS-1:0]         match_vld,
    output logic [N_PORTS*PW-1:0]      match_out
);
    localparam int N  = N_PORTS;
    localparam int IW = (N_ITERS > 1) ? $clog2(N_ITERS) : 1;

    typedef struct packed {
        phase_e                phase;
        logic [IW-1:0]         iter;
        logic [N-1:0][N-1:0]   req;
        logic [N-1:0]          in_busy;
        logic [N-1:0]          out_busy;
        logic [N-1:0][PW-1:0]  sel;
        logic [N-1:0][PW-1:0]  gptr;
        logic [N-1:0][PW-1:0]  aptr;
        logic                  done;
    } state_t;

    state_t state_d, state_q;

    logic [N-1:0][N-1:0] acc;
    logic                running;
    logic                first_iter;
    logic [N*PW-1:0]     gptr_flat;
    logic [N*PW-1:0]     aptr_flat;

    xbar_iter_stage #(.N(N), .PW(PW)) u_stage (
        .req      (state_q.req),
        .in_free  (~state_q.in_busy),
        .out_free (~state_q.out_busy),
        .gptr     (state_q.gptr),
        .aptr     (state_q.aptr),
        .acc      (acc)
    );

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] v);
        return (int'(v) == N - 1) ? '0 : v + PW'(1);
    endfunction

    always_comb begin
        logic [PW-1:0] enc;
        logic          hit;
        state_d      = state_q;
        state_d.done = 1'b0;
        case (state_q.phase)
            PH_IDLE: begin
                if (start) begin
                    state_d.phase    = PH_RUN;
                    state_d.iter     = '0;
                    state_d.in_busy  = '0;
                    state_d.out_busy = '0;
                    state_d.sel      = '0;
                    for (int i = 0; i < N; i++) begin
                        for (int j = 0; j < N; j++) begin
                            state_d.req[i][j] = req_mat[i*N+j];
                        end
                    end
                end
            end
            default: begin
                for (int i = 0; i < N; i++) begin
                    enc = '0;
                    hit = 1'b0;
                    for (int j = 0; j < N; j++) begin
                        if (acc[i][j]) begin
                            enc = PW'(j);
                            hit = 1'b1;
                        end
                    end
                    if (hit) begin
                        state_d.in_busy[i]   = 1'b1;
                        state_d.out_busy[enc] = 1'b1;
                        state_d.sel[i]       = enc;
                        if (state_q.iter == '0) begin
                            state_d.aptr[i]   = wrap_inc(enc);
                            state_d.gptr[enc] = wrap_inc(PW'(i));
                        end
                    end
                end
                if (state_q.iter == IW'(N_ITERS - 1)) begin
                    state_d.phase = PH_IDLE;
                    state_d.done  = 1'b1;
                end else begin
                    state_d.iter = state_q.iter + IW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            match_out[i*PW +: PW] = state_q.sel[i];
            gptr_flat[i*PW +: PW] = state_q.gptr[i];
            aptr_flat[i*PW +: PW] = state_q.aptr[i];
        end
    end

    assign done       = state_q.done;
    assign match_vld  = state_q.in_busy;
    assign running    = (state_q.phase == PH_RUN);
    assign first_iter = running && (state_q.iter == '0);
endmodule

// File: rtl/xbar_matcher_chk.sv
module xbar_matcher_chk #(
    parameter int N_PORTS = 4,
    parameter int PW      = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start,
    input logic [N_PORTS*N_PORTS-1:0] req_mat,
    input logic                       done,
    input logic [N_PORTS-1:0]         match_vld,
    input logic [N_PORTS*PW-1:0]      match_out,
    input logic                       running,
    input logic                       first_iter,
    input logic [N_PORTS*PW-1:0]      gptr_flat,
    input logic [N_PORTS*PW-1:0]      aptr_flat
);
    localparam int N = N_PORTS;

    logic [N*N-1:0] cap_req;
    logic [N-1:0]   col_multi;
    logic [N-1:0]   not_req;
    logic [N-1:0]   idle_nonzero;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_req <= '0;
        end else if (start && !running) begin
            cap_req <= req_mat;
        end
    end

    always_comb begin
        int cnt;
        for (int j = 0; j < N; j++) begin
            cnt = 0;
            for (int i = 0; i < N; i++) begin
                if (match_vld[i] && int'(match_out[i*PW +: PW]) == j) cnt++;
            end
            col_multi[j] = (cnt > 1);
        end
        for (int i = 0; i < N; i++) begin
            not_req[i]      = match_vld[i] && !cap_req[i*N + int'(match_out[i*PW +: PW])];
            idle_nonzero[i] = !match_vld[i] && (match_out[i*PW +: PW] != '0);
        end
    end

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(running));
    p_one_per_output_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (col_multi == '0));
    p_pair_requested_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (not_req == '0));
    p_ptr_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !first_iter |=> ($stable(gptr_flat) && $stable(aptr_flat)));
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start) |=> ($stable(match_vld) && $stable(match_out)));
    p_unpaired_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (idle_nonzero == '0));
endmodule

bind xbar_matcher xbar_matcher_chk #(.N_PORTS(N_PORTS), .PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .req_mat    (req_mat),
    .done       (done),
    .match_vld  (match_vld),
    .match_out  (match_out),
    .running    (running),
    .first_iter (first_iter),
    .gptr_flat  (gptr_flat),
    .aptr_flat  (aptr_flat)
);

// File: tb/xbar_matcher_bench.sv
module xbar_matcher_bench;
    localparam int N  = 4;
    localparam int IT = 2;
    localparam int PW = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N*N-1:0] req_mat = '0;
    logic           done;
    logic [N-1:0]   match_vld;
    logic [N*PW-1:0] match_out;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    xbar_matcher #(.N_PORTS(N), .N_ITERS(IT)) u_xbar_matcher (
        .clk(clk), .rst_n(rst_n), .start(start), .req_mat(req_mat),
        .done(done), .match_vld(match_vld), .match_out(match_out)
    );

    // behavioural reference, stepped once per rising edge
    bit m_run, m_done;
    int m_iter;
    bit m_req [N][N];
    bit m_inb [N];
    bit m_outb[N];
    int m_sel [N];
    int m_gp  [N];
    int m_ap  [N];

    always @(posedge clk) begin
        int g[N];
        int a;
        if (!rst_n) begin
            m_run = 0; m_done = 0; m_iter = 0;
            for (int i = 0; i < N; i++) begin
                m_inb[i] = 0; m_outb[i] = 0; m_sel[i] = 0; m_gp[i] = 0; m_ap[i] = 0;
                for (int j = 0; j < N; j++) m_req[i][j] = 0;
            end
        end else begin
            m_done = 0;
            if (!m_run) begin
                if (start) begin
                    m_run = 1; m_iter = 0;
                    for (int i = 0; i < N; i++) begin
                        m_inb[i] = 0; m_outb[i] = 0; m_sel[i] = 0;
                        for (int j = 0; j < N; j++) m_req[i][j] = req_mat[i*N+j];
                    end
                end
            end else begin
                for (int j = 0; j < N; j++) begin
                    g[j] = -1;
                    if (!m_outb[j]) begin
                        for (int k = 0; k < N; k++) begin
                            int i2;
                            i2 = (m_gp[j] + k) % N;
                            if (g[j] < 0 && !m_inb[i2] && m_req[i2][j]) g[j] = i2;
                        end
                    end
                end
                for (int i = 0; i < N; i++) begin
                    if (!m_inb[i]) begin
                        a = -1;
                        for (int k = 0; k < N; k++) begin
                            int j2;
                            j2 = (m_ap[i] + k) % N;
                            if (a < 0 && g[j2] == i) a = j2;
                        end
                        if (a >= 0) begin
                            m_inb[i] = 1; m_outb[a] = 1; m_sel[i] = a;
                            if (m_iter == 0) begin
                                m_ap[i] = (a + 1) % N;
                                m_gp[a] = (i + 1) % N;
                            end
                        end
                    end
                end
                if (m_iter == IT - 1) begin m_run = 0; m_done = 1; end
                else m_iter++;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(done == m_done, "R2 done", int'(done), int'(m_done));
            for (int i = 0; i < N; i++) begin
                chk(match_vld[i] == m_inb[i], "R3 match_vld", int'(match_vld[i]), int'(m_inb[i]));
                chk(int'(match_out[i*PW +: PW]) == m_sel[i], "R4/R6 match_out",
                    int'(match_out[i*PW +: PW]), m_sel[i]);
            end
        end
    end

    task automatic run_cell(input logic [N*N-1:0] m, input bit double_start);
        int cyc;
        @(negedge clk);
        start = 1'b1; req_mat = m;
        @(negedge clk);
        start = double_start;
        cyc = 0;
        while (!done && cyc < 20) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        chk(cyc == IT, "R2 done latency", cyc, IT);
    endtask

    task automatic expect_pair(input int inp, input bit v, input int port, input string rq);
        chk(match_vld[inp] == v, rq, int'(match_vld[inp]), int'(v));
        chk(int'(match_out[inp*PW +: PW]) == port, rq, int'(match_out[inp*PW +: PW]), port);
    endtask

    initial begin
        logic [N*N-1:0] rm;
        logic [N-1:0]   held_v;
        logic [N*PW-1:0] held_o;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(match_vld == '0, "R1 match_vld", int'(match_vld), 0);
        chk(match_out == '0, "R1 match_out", int'(match_out), 0);
        rst_n = 1'b1;

        // full load, pointers from reset (R1, R4, R6, R7)
        run_cell('1, 1'b0);
        expect_pair(0, 1, 0, "R4 cell1 in0");
        expect_pair(1, 1, 1, "R7 cell1 in1");
        expect_pair(2, 0, 0, "R9 cell1 in2");
        expect_pair(3, 0, 0, "R9 cell1 in3");

        // full load again: only first-round pointers moved (R5, R6, R7)
        run_cell('1, 1'b0);
        expect_pair(0, 1, 1, "R6 cell2 in0");
        expect_pair(1, 1, 0, "R5 cell2 in1");
        expect_pair(2, 1, 2, "R7 cell2 in2");
        expect_pair(3, 0, 0, "R9 cell2 in3");

        // R8 result holds while idle
        held_v = match_vld; held_o = match_out;
        repeat (5) @(negedge clk);
        chk(match_vld == held_v, "R8 hold vld", int'(match_vld), int'(held_v));
        chk(match_out == held_o, "R8 hold out", int'(match_out), int'(held_o));

        // R2 start during rounds ignored: only one done pulse follows
        run_cell(16'h8421, 1'b1);
        repeat (IT + 2) begin
            @(negedge clk);
            chk(done == 1'b0, "R2 extra start", int'(done), 0);
        end

        // empty matrix clears the result (R8, R9)
        run_cell('0, 1'b0);
        chk(match_vld == '0, "R8 cleared", int'(match_vld), 0);

        // single request input 3 -> output 2 (bit 14)
        run_cell(16'h4000, 1'b0);
        expect_pair(3, 1, 2, "R3 single");

        // varied loads compared against the model (R3-R7)
        for (int c = 0; c < 300; c++) begin
            case (c % 3)
                0: rm = N*N'($urandom);
                1: rm = N*N'($urandom & $urandom);
                default: rm = N*N'($urandom | $urandom);
            endcase
            run_cell(rm, (c % 7) == 0);
        end

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule